// File: doc/BRIEF.md
# Mouse movement report assembler

This block sits behind a PS/2 frame receiver and turns its byte stream into complete movement reports from a mouse in stream mode. A report always arrives as three bytes: a header byte holding button and sign/overflow flags, then the horizontal movement byte, then the vertical movement byte. The assembler collects the three bytes and forms two signed 9-bit movement values. It then presents the buttons, the movements and the overflow flags together with a single-cycle strobe.

The assembler keeps itself aligned to report boundaries. A byte is taken as a header only if its alignment marker bit (bit 3) is set, and any other byte arriving while a header is expected is dropped. Two events abandon a partly collected report, after which the block looks for a fresh header: a byte flagged with a framing error, or a silence between bytes that reaches a programmable cycle count. That count is about 2 ms at the system clock.

Top module: `mouse_report_asm`

## Requirements
- R1: While and right after reset, `rpt_strobe` is 0 and every report output is 0.
- R2: After a header, horizontal and vertical byte are accepted in that order, `rpt_strobe` is 1 for exactly one cycle, in the cycle after the vertical byte is sampled, and one strobe is produced for each complete report.
- R3: `btn_left`, `btn_right` and `btn_middle` equal header bits 0, 1 and 2 of the report just completed (1 = pressed).
- R4: `delta_x` is the 9-bit two's-complement value {header bit 4, horizontal byte} and `delta_y` is {header bit 5, vertical byte}; a sign bit of 1 means leftward or downward.
- R5: `ovf_x` equals header bit 6 and `ovf_y` equals header bit 7.
- R6: While a header is expected, an error-free byte with bit 3 equal to 0 is discarded and produces no report.
- R7: A byte presented with `in_err` high is discarded; a partially collected report is abandoned and the next byte is examined as a header.
- R8: Once a header has been accepted, if `GAP_LIMIT` or more consecutive cycles pass with `in_valid` low, the partial report is abandoned and the next byte is examined as a header; shorter gaps do not disturb collection.
- R9: The report outputs hold their values in every cycle except the one in which a new report is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| in_err | input | 1 | The present byte had a framing or parity error |
| rpt_strobe | output | 1 | One-cycle pulse: a new report is on the outputs |
| btn_left | output | 1 | Left button pressed |
| btn_right | output | 1 | Right button pressed |
| btn_middle | output | 1 | Middle button pressed |
| delta_x | output | 9 | Signed horizontal movement |
| delta_y | output | 9 | Signed vertical movement |
| ovf_x | output | 1 | Horizontal magnitude overflowed |
| ovf_y | output | 1 | Vertical magnitude overflowed |

## Verification
The assertions assume that `in_valid` is a single-cycle qualifier per byte and that `in_err` only has meaning when `in_valid` is high. The bench drives each byte as a one-cycle pulse, holds `in_err` low except on the deliberately bad byte, and sets the silence between bytes in exact idle-cycle counts. This lets the gap boundary be placed one cycle either side of `GAP_LIMIT`. `GAP_LIMIT` is lowered to a small value so that the timeout path is reached quickly.

// File: rtl/mouse_report_pkg.sv
package mouse_report_pkg;

    localparam int MBYTE_W   = 8;
    localparam int DELTA_W   = MBYTE_W + 1;

    // header bit positions (fixed by the mouse's report layout)
    localparam int HB_LEFT   = 0;
    localparam int HB_RIGHT  = 1;
    localparam int HB_MIDDLE = 2;
    localparam int HB_MARK   = 3;
    localparam int HB_SGN_X  = 4;
    localparam int HB_SGN_Y  = 5;
    localparam int HB_OVF_X  = 6;
    localparam int HB_OVF_Y  = 7;

    typedef enum logic [1:0] {
        PH_HEAD = 2'd0,
        PH_HORZ = 2'd1,
        PH_VERT = 2'd2
    } phase_e;

    typedef struct packed {
        logic               left;
        logic               right;
        logic               middle;
        logic               ovf_x;
        logic               ovf_y;
        logic [DELTA_W-1:0] dx;
        logic [DELTA_W-1:0] dy;
    } report_t;

    function automatic logic [DELTA_W-1:0] widen(input logic sgn,
                                                 input logic [MBYTE_W-1:0] mag);
        return {sgn, mag};
    endfunction

    function automatic report_t form_report(input logic [MBYTE_W-1:0] hdr,
                                            input logic [MBYTE_W-1:0] hx,
                                            input logic [MBYTE_W-1:0] vy);
        report_t r;
        r.left   = hdr[HB_LEFT];
        r.right  = hdr[HB_RIGHT];
        r.middle = hdr[HB_MIDDLE];
        r.ovf_x  = hdr[HB_OVF_X];
        r.ovf_y  = hdr[HB_OVF_Y];
        r.dx     = widen(hdr[HB_SGN_X], hx);
        r.dy     = widen(hdr[HB_SGN_Y], vy);
        return r;
    endfunction

endpackage

// File: rtl/mouse_gap_timer.sv
module mouse_gap_timer #(
    parameter int GAP_LIMIT = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic byte_seen,
    output logic expire
);
    localparam int CNT_W = $clog2(GAP_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(GAP_LIMIT);

    logic [CNT_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy || byte_seen) begin
            idle_cnt <= '0;
        end else if (idle_cnt < LIMIT_V) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign expire = busy && (idle_cnt >= LIMIT_V);

    // R8
    idle_reset_chk: assert property (@(posedge clk) disable iff (rst)
        byte_seen |=> !expire);

endmodule

// File: rtl/mouse_byte_sequencer.sv
module mouse_byte_sequencer
    import mouse_report_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_err,
    input  logic [MBYTE_W-1:0] in_byte,
    input  logic               expire,
    output logic               busy,
    output logic               done,
    output logic [MBYTE_W-1:0] hdr_q,
    output logic [MBYTE_W-1:0] horz_q
);
    phase_e phase, phase_nx, eff;
    logic   good;
    logic   take_hdr, take_horz;

    assign eff  = expire ? PH_HEAD : phase;
    assign good = in_valid && !in_err;

    always_comb begin
        phase_nx  = eff;
        take_hdr  = 1'b0;
        take_horz = 1'b0;
        done      = 1'b0;
        if (in_valid && in_err) begin
            phase_nx = PH_HEAD;
        end else if (good) begin
            unique case (eff)
                PH_HEAD: begin
                    if (in_byte[HB_MARK]) begin
                        take_hdr = 1'b1;
                        phase_nx = PH_HORZ;
                    end
                end
                PH_HORZ: begin
                    take_horz = 1'b1;
                    phase_nx  = PH_VERT;
                end
                PH_VERT: begin
                    done     = 1'b1;
                    phase_nx = PH_HEAD;
                end
                default: phase_nx = PH_HEAD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_HEAD;
            hdr_q  <= '0;
            horz_q <= '0;
        end else begin
            phase <= phase_nx;
            if (take_hdr)  hdr_q  <= in_byte;
            if (take_horz) horz_q <= in_byte;
        end
    end

    assign busy = (phase != PH_HEAD);

    // R6
    unmarked_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && good && !in_byte[HB_MARK]) |=> !busy);

    // R7
    err_abandon_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_err) |=> !busy);

    // R8
    gap_abandon_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && !in_valid) |=> !busy);

    // R3
    hdr_marked_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> hdr_q[HB_MARK]);

endmodule

// File: rtl/mouse_report_reg.sv
module mouse_report_reg
    import mouse_report_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [MBYTE_W-1:0] hdr,
    input  logic [MBYTE_W-1:0] horz,
    input  logic [MBYTE_W-1:0] vert,
    output report_t            rpt,
    output logic               strobe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rpt    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= load;
            if (load) rpt <= form_report(hdr, horz, vert);
        end
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(rpt));

    // R5
    ovf_map_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (rpt.ovf_x == $past(hdr[HB_OVF_X]) && rpt.ovf_y == $past(hdr[HB_OVF_Y])));

    // R3
    btn_map_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (rpt.left == $past(hdr[HB_LEFT]) && rpt.middle == $past(hdr[HB_MIDDLE])));

endmodule

// File: rtl/mouse_report_asm.sv
module mouse_report_asm
    import mouse_report_pkg::*;
#(
    parameter int GAP_LIMIT = 200000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    input  logic               in_err,
    output logic               rpt_strobe,
    output logic               btn_left,
    output logic               btn_right,
    output logic               btn_middle,
    output logic [8:0]         delta_x,
    output logic [8:0]         delta_y,
    output logic               ovf_x,
    output logic               ovf_y
);
    logic               busy, expire, done;
    logic [MBYTE_W-1:0] hdr_q, horz_q;
    report_t            rpt;

    mouse_gap_timer #(.GAP_LIMIT(GAP_LIMIT)) gap_i (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .byte_seen (in_valid),
        .expire    (expire)
    );

    mouse_byte_sequencer seq_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_err   (in_err),
        .in_byte  (in_byte),
        .expire   (expire),
        .busy     (busy),
        .done     (done),
        .hdr_q    (hdr_q),
        .horz_q   (horz_q)
    );

    mouse_report_reg rreg_i (
        .clk    (clk),
        .rst    (rst),
        .load   (done),
        .hdr    (hdr_q),
        .horz   (horz_q),
        .vert   (in_byte),
        .rpt    (rpt),
        .strobe (rpt_strobe)
    );

    assign btn_left   = rpt.left;
    assign btn_right  = rpt.right;
    assign btn_middle = rpt.middle;
    assign delta_x    = rpt.dx;
    assign delta_y    = rpt.dy;
    assign ovf_x      = rpt.ovf_x;
    assign ovf_y      = rpt.ovf_y;

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        rpt_strobe |=> !rpt_strobe);

    // R2
    strobe_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        rpt_strobe |-> $past(in_valid));

endmodule

// File: tb/mouse_report_asm_tb_top.sv
module mouse_report_asm_tb_top;

    localparam int GAP = 20;

    typedef struct packed {
        logic l, r, m, ox, oy;
        int   dx;
        int   dy;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_err = 1'b0;
    logic       rpt_strobe, btn_left, btn_right, btn_middle, ovf_x, ovf_y;
    logic [8:0] delta_x, delta_y;

    int   total = 0;
    int   bad = 0;
    int   pushed = 0;
    int   seen = 0;
    bit   finished = 0;
    logic prev_strobe = 1'b0;
    exp_t exp_q[$];
    exp_t last_exp;

    always #5 clk = ~clk;

    mouse_report_asm #(.GAP_LIMIT(GAP)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_err(in_err),
        .rpt_strobe(rpt_strobe), .btn_left(btn_left), .btn_right(btn_right),
        .btn_middle(btn_middle), .delta_x(delta_x), .delta_y(delta_y),
        .ovf_x(ovf_x), .ovf_y(ovf_y)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // caller is at a negedge; leaves exactly gap idle cycles after the byte
    task automatic send_byte(input logic [7:0] b, input logic e, input int gap);
        in_valid = 1'b1;
        in_byte  = b;
        in_err   = e;
        @(negedge clk);
        in_valid = 1'b0;
        in_err   = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_report(input logic [7:0] s, input logic [7:0] x,
                               input logic [7:0] y, input int gap);
        exp_t e;
        e.l  = s[0];
        e.r  = s[1];
        e.m  = s[2];
        e.ox = s[6];
        e.oy = s[7];
        e.dx = s[4] ? int'(x) - 256 : int'(x);
        e.dy = s[5] ? int'(y) - 256 : int'(y);
        exp_q.push_back(e);
        pushed++;
        send_byte(s, 1'b0, gap);
        send_byte(x, 1'b0, gap);
        send_byte(y, 1'b0, 2);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (rpt_strobe) begin
                exp_t e;
                seen++;
                check(!prev_strobe, "R2 strobe width", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected report", seen, pushed);
                end else begin
                    e = exp_q.pop_front();
                    last_exp = e;
                    check({btn_left, btn_right, btn_middle} == {e.l, e.r, e.m}, "R3 buttons",
                          int'({btn_left, btn_right, btn_middle}), int'({e.l, e.r, e.m}));
                    check(int'($signed(delta_x)) == e.dx, "R4 delta_x", int'($signed(delta_x)), e.dx);
                    check(int'($signed(delta_y)) == e.dy, "R4 delta_y", int'($signed(delta_y)), e.dy);
                    check({ovf_x, ovf_y} == {e.ox, e.oy}, "R5 overflow",
                          int'({ovf_x, ovf_y}), int'({e.ox, e.oy}));
                end
            end
            prev_strobe = rpt_strobe;
        end
    end

    task automatic summary();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({rpt_strobe, btn_left, btn_right, btn_middle, ovf_x, ovf_y, delta_x, delta_y} == '0,
              "R1 during reset", int'(delta_x), 0);
        rst = 1'b0;
        @(negedge clk);
        check({rpt_strobe, btn_left, btn_right, btn_middle, ovf_x, ovf_y, delta_x, delta_y} == '0,
              "R1 after reset", int'(rpt_strobe), 0);

        // R2 R3 R4: plain, negative and overflow reports
        send_report(8'h09, 8'h05, 8'h10, 0);
        send_report(8'h3E, 8'hFB, 8'h80, 1);
        send_report(8'hC8, 8'hFF, 8'h00, 3);
        send_report(8'h1F, 8'h00, 8'h7F, 0);

        // R9: outputs hold long after the strobe
        repeat (10) @(negedge clk);
        check(int'($signed(delta_x)) == last_exp.dx && int'($signed(delta_y)) == last_exp.dy &&
              btn_left == last_exp.l, "R9 hold", int'($signed(delta_x)), last_exp.dx);

        // R6: unmarked bytes while expecting a header are dropped
        send_byte(8'h07, 1'b0, 1);
        send_byte(8'hF0, 1'b0, 1);
        send_report(8'h0A, 8'h21, 8'hE0, 0);
        repeat (3) @(negedge clk);
        check(seen == pushed, "R6 unmarked dropped", seen, pushed);

        // R7: error byte abandons a partial report
        send_byte(8'h09, 1'b0, 0);
        send_byte(8'h33, 1'b0, 0);
        send_byte(8'h44, 1'b1, 1);
        send_byte(8'h0C, 1'b1, 1);
        send_report(8'h0C, 8'h12, 8'h34, 0);
        repeat (3) @(negedge clk);
        check(seen == pushed, "R7 error abandon", seen, pushed);

        // R8: gap one below the limit keeps the report
        send_report(8'h29, 8'h40, 8'h02, GAP - 1);
        repeat (3) @(negedge clk);
        check(seen == pushed, "R8 short gap kept", seen, pushed);

        // R8: gap at the limit abandons; the late byte is then judged as header
        send_byte(8'h0B, 1'b0, 0);
        send_byte(8'h55, 1'b0, GAP);
        send_byte(8'h01, 1'b0, 1);
        send_report(8'h0E, 8'h66, 8'h77, 0);
        repeat (3) @(negedge clk);
        check(seen == pushed, "R8 gap abandon", seen, pushed);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2 reports outstanding", exp_q.size(), 0);
        check(seen == pushed, "R2 report count", seen, pushed);
        summary();
    end

endmodule